// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small multi-cycle processor. A constant microcode store, addressed by a registered micro-PC, replaces a hand-drawn state machine. Each cycle, the word at the current micro-PC drives the datapath controls directly: ALU operation, the two ALU source selects, register-file action, memory action and PC-write source. A two-bit sequencing field in the same word picks the next micro-PC. The next micro-PC is either the current one plus one, the fetch entry, or a target found in one of two opcode-indexed dispatch lookups.

The surrounding datapath holds the instruction register and presents its 6-bit opcode on `opcode`. The block only decides control. It has no data stream, so every pin is a plain level signal and there is no handshake. If a dispatch lookup finds no entry for the opcode, `illegal_op` is raised for that cycle and the sequencer goes back to fetch.

Instruction classes and their micro-PC paths:

| Class | Opcode | Micro-PC path | Cycles |
|---|---|---|---|
| Load | 0x23 | 0,1,2,3,4 | 5 |
| Store | 0x2B | 0,1,2,5 | 4 |
| Register ALU | 0x00 | 0,1,6,7 | 4 |
| Branch-equal | 0x04 | 0,1,8 | 3 |
| Jump | 0x02 | 0,1,9 | 3 |

Field encodings:

| Field | Values |
|---|---|
| alu_op | 0 add, 1 subtract, 2 function-field |
| src1_sel | 0 PC, 1 register A |
| src2_sel | 0 register B, 1 constant 4, 2 sign-extended immediate, 3 shifted sign-extended immediate |
| rf_ctl | 0 none, 1 read, 2 write ALU result, 3 write memory data register |
| mem_ctl | 0 none, 1 read at PC, 2 read at ALU output, 3 write at ALU output |
| pc_ctl | 0 none, 1 ALU result, 2 conditional branch target, 3 jump address |

Top module: `mseq_top`

## Requirements
- R1: While rst_n is low (asynchronous, active low), upc is 0. After release, the first outputs are those of the fetch word.
- R2: At upc 0 the outputs are alu_op=0, src1_sel=0, src2_sel=1, rf_ctl=0, mem_ctl=1, pc_ctl=1, and the next upc is 1.
- R3: At upc 1 the outputs are alu_op=0, src1_sel=0, src2_sel=3, rf_ctl=1, mem_ctl=0, pc_ctl=0. The next upc comes from the first dispatch lookup: 0x23 and 0x2B go to 2, 0x00 to 6, 0x04 to 8, 0x02 to 9.
- R4: At upc 2 the outputs are alu_op=0, src1_sel=1, src2_sel=2, with no register, memory or PC action. The next upc comes from the second dispatch lookup: 0x23 goes to 3 and 0x2B to 5.
- R5: A load (0x23) walks upc 0,1,2,3,4 and then returns to 0. Upc 3 gives mem_ctl=2. Upc 4 gives rf_ctl=3. All other fields are 0 in both.
- R6: A store (0x2B) walks upc 0,1,2,5 and then returns to 0. Upc 5 gives mem_ctl=3 and all other fields 0.
- R7: A register ALU instruction (0x00) walks upc 0,1,6,7 and then returns to 0. Upc 6 gives alu_op=2, src1_sel=1, src2_sel=0. Upc 7 gives rf_ctl=2 and all other fields 0.
- R8: A branch-equal (0x04) walks upc 0,1,8 and then returns to 0. Upc 8 gives alu_op=1, src1_sel=1, src2_sel=0, pc_ctl=2.
- R9: A jump (0x02) walks upc 0,1,9 and then returns to 0. Upc 9 gives pc_ctl=3 and all other fields 0.
- R10: If the first dispatch lookup has no entry for the opcode at upc 1, illegal_op is 1 in that cycle and the next upc is 0.
- R11: If the second dispatch lookup has no entry for the opcode at upc 2, illegal_op is 1 in that cycle and the next upc is 0.
- R12: illegal_op is 0 in every cycle whose upc is neither 1 nor 2, and upc never leaves the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OPC_W (6) | Opcode from the instruction register |
| upc | output | UADDR_W (4) | Current micro-PC |
| alu_op | output | 2 | ALU operation select |
| src1_sel | output | 1 | ALU first source select |
| src2_sel | output | 2 | ALU second source select |
| rf_ctl | output | 2 | Register-file action |
| mem_ctl | output | 2 | Memory action |
| pc_ctl | output | 2 | PC write source |
| illegal_op | output | 1 | Dispatch lookup found no entry this cycle |

## Verification
The micro-PC is itself an output, so a corrupted sequencer state shows at `upc` in the same cycle it is taken. A wrong dispatch target shows one cycle after decode or after the memory-address word. A wrong field slice or a wrong word in the store changes the control outputs in the very cycle that address is visited, so each class's path is checked word by word. A missing or spurious illegal-opcode entry shows both on `illegal_op` and as a return to address 0 on the next edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_RSV = 2'd3} alu_e;
  typedef enum logic       {S1_PC = 1'b0, S1_A = 1'b1} src1_e;
  typedef enum logic [1:0] {S2_B = 2'd0, S2_FOUR = 2'd1, S2_EXT = 2'd2, S2_EXTSH = 2'd3} src2_e;
  typedef enum logic [1:0] {RF_NONE = 2'd0, RF_READ = 2'd1, RF_WR_ALU = 2'd2, RF_WR_MDR = 2'd3} rf_e;
  typedef enum logic [1:0] {MEM_NONE = 2'd0, MEM_RD_PC = 2'd1, MEM_RD_ALU = 2'd2, MEM_WR_ALU = 2'd3} mem_e;
  typedef enum logic [1:0] {PC_NONE = 2'd0, PC_ALU = 2'd1, PC_COND = 2'd2, PC_JUMP = 2'd3} pcw_e;
  typedef enum logic [1:0] {SQ_NEXT = 2'd0, SQ_FETCH = 2'd1, SQ_DISP1 = 2'd2, SQ_DISP2 = 2'd3} seq_e;

  // Fixed bit slices, MSB first: alu[12:11] s1[10] s2[9:8] rf[7:6] mem[5:4] pc[3:2] seq[1:0]
  typedef struct packed {
    alu_e  alu;
    src1_e s1;
    src2_e s2;
    rf_e   rf;
    mem_e  mem;
    pcw_e  pc;
    seq_e  seq;
  } uword_t;

  // Micro-addresses of the store entries
  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_MADDR  = 2;
  localparam int UA_LDRD   = 3;
  localparam int UA_LDWB   = 4;
  localparam int UA_STWR   = 5;
  localparam int UA_REXE   = 6;
  localparam int UA_RWB    = 7;
  localparam int UA_BEQ    = 8;
  localparam int UA_JMP    = 9;

  // Opcode values recognised by the dispatch lookups
  localparam int OP_RALU  = 'h00;
  localparam int OP_JMP   = 'h02;
  localparam int OP_BEQ   = 'h04;
  localparam int OP_LOAD  = 'h23;
  localparam int OP_STORE = 'h2B;

  function automatic uword_t mk(alu_e a, src1_e s1, src2_e s2, rf_e rf, mem_e m, pcw_e p, seq_e q);
    uword_t w;
    w.alu = a; w.s1 = s1; w.s2 = s2; w.rf = rf; w.mem = m; w.pc = p; w.seq = q;
    return w;
  endfunction

  // Contents of the microcode store; unused entries fall back to fetch doing nothing
  function automatic uword_t ustore(int unsigned addr);
    case (addr)
      UA_FETCH:  return mk(ALU_ADD,  S1_PC, S2_FOUR,  RF_NONE,   MEM_RD_PC,  PC_ALU,  SQ_NEXT);
      UA_DECODE: return mk(ALU_ADD,  S1_PC, S2_EXTSH, RF_READ,   MEM_NONE,   PC_NONE, SQ_DISP1);
      UA_MADDR:  return mk(ALU_ADD,  S1_A,  S2_EXT,   RF_NONE,   MEM_NONE,   PC_NONE, SQ_DISP2);
      UA_LDRD:   return mk(ALU_ADD,  S1_PC, S2_B,     RF_NONE,   MEM_RD_ALU, PC_NONE, SQ_NEXT);
      UA_LDWB:   return mk(ALU_ADD,  S1_PC, S2_B,     RF_WR_MDR, MEM_NONE,   PC_NONE, SQ_FETCH);
      UA_STWR:   return mk(ALU_ADD,  S1_PC, S2_B,     RF_NONE,   MEM_WR_ALU, PC_NONE, SQ_FETCH);
      UA_REXE:   return mk(ALU_FUNC, S1_A,  S2_B,     RF_NONE,   MEM_NONE,   PC_NONE, SQ_NEXT);
      UA_RWB:    return mk(ALU_ADD,  S1_PC, S2_B,     RF_WR_ALU, MEM_NONE,   PC_NONE, SQ_FETCH);
      UA_BEQ:    return mk(ALU_SUB,  S1_A,  S2_B,     RF_NONE,   MEM_NONE,   PC_COND, SQ_FETCH);
      UA_JMP:    return mk(ALU_ADD,  S1_PC, S2_B,     RF_NONE,   MEM_NONE,   PC_JUMP, SQ_FETCH);
      default:   return mk(ALU_ADD,  S1_PC, S2_B,     RF_NONE,   MEM_NONE,   PC_NONE, SQ_FETCH);
    endcase
  endfunction

endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic [UADDR_W-1:0] addr,
  output uword_t             word
);
  localparam int DEPTH = 1 << UADDR_W;

  uword_t store [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign store[g] = ustore(g);
  end

  assign word = store[addr];
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
  import mseq_pkg::*;
#(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4,
  parameter int TABLE   = 1
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic               hit,
  output logic [UADDR_W-1:0] target
);
  if (TABLE == 1) begin : g_tbl1
    always_comb begin
      hit    = 1'b1;
      target = UADDR_W'(UA_FETCH);
      case (opcode)
        OPC_W'(OP_LOAD),
        OPC_W'(OP_STORE): target = UADDR_W'(UA_MADDR);
        OPC_W'(OP_RALU):  target = UADDR_W'(UA_REXE);
        OPC_W'(OP_BEQ):   target = UADDR_W'(UA_BEQ);
        OPC_W'(OP_JMP):   target = UADDR_W'(UA_JMP);
        default:          hit    = 1'b0;
      endcase
    end
  end else begin : g_tbl2
    always_comb begin
      hit    = 1'b1;
      target = UADDR_W'(UA_FETCH);
      case (opcode)
        OPC_W'(OP_LOAD):  target = UADDR_W'(UA_LDRD);
        OPC_W'(OP_STORE): target = UADDR_W'(UA_STWR);
        default:          hit    = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_e               seq,
  input  logic               hit1,
  input  logic [UADDR_W-1:0] tgt1,
  input  logic               hit2,
  input  logic [UADDR_W-1:0] tgt2,
  output logic [UADDR_W-1:0] upc,
  output logic               illegal
);
  localparam logic [UADDR_W-1:0] FETCH = UADDR_W'(UA_FETCH);

  logic [UADDR_W-1:0] upc_nxt;

  always_comb begin
    illegal = 1'b0;
    case (seq)
      SQ_NEXT:  upc_nxt = upc + 1'b1;
      SQ_DISP1: begin
        upc_nxt = hit1 ? tgt1 : FETCH;
        illegal = ~hit1;
      end
      SQ_DISP2: begin
        upc_nxt = hit2 ? tgt2 : FETCH;
        illegal = ~hit2;
      end
      default:  upc_nxt = FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= FETCH;
    else        upc <= upc_nxt;
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] upc,
  output logic [1:0]         alu_op,
  output logic               src1_sel,
  output logic [1:0]         src2_sel,
  output logic [1:0]         rf_ctl,
  output logic [1:0]         mem_ctl,
  output logic [1:0]         pc_ctl,
  output logic               illegal_op
);
  uword_t             cur;
  logic               hit1, hit2;
  logic [UADDR_W-1:0] tgt1, tgt2;

  mseq_rom #(.UADDR_W(UADDR_W)) u_rom (
    .addr (upc),
    .word (cur)
  );

  mseq_dispatch #(.OPC_W(OPC_W), .UADDR_W(UADDR_W), .TABLE(1)) u_disp1 (
    .opcode (opcode),
    .hit    (hit1),
    .target (tgt1)
  );

  mseq_dispatch #(.OPC_W(OPC_W), .UADDR_W(UADDR_W), .TABLE(2)) u_disp2 (
    .opcode (opcode),
    .hit    (hit2),
    .target (tgt2)
  );

  mseq_next #(.UADDR_W(UADDR_W)) u_next (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq     (cur.seq),
    .hit1    (hit1),
    .tgt1    (tgt1),
    .hit2    (hit2),
    .tgt2    (tgt2),
    .upc     (upc),
    .illegal (illegal_op)
  );

  assign alu_op   = cur.alu;
  assign src1_sel = cur.s1;
  assign src2_sel = cur.s2;
  assign rf_ctl   = cur.rf;
  assign mem_ctl  = cur.mem;
  assign pc_ctl   = cur.pc;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [OPC_W-1:0]   opcode,
  input logic [UADDR_W-1:0] upc,
  input logic               illegal_op
);
  // R1: a reset sampled at an edge leaves the sequencer at fetch
  a_r1_reset_to_fetch: assert property (@(posedge clk) !rst_n |=> upc == 0);

  // R2: fetch always advances to decode
  a_r2_fetch_next: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 0 |=> upc == 1);

  // R3: a legal decode lands on one of the class entry words
  a_r3_decode_target: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 1 && !illegal_op) |=> (upc == 2 || upc == 6 || upc == 8 || upc == 9));

  // R5: load steps in order and then finishes
  a_r5_load_read: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 3 |=> upc == 4);
  a_r5_load_done: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4 |=> upc == 0);

  // R10, R11: a missed lookup goes back to fetch
  a_r10_illegal_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> upc == 0);

  // R12: illegal flag only on dispatching words, upc in range
  a_r12_illegal_only_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (upc == 1 || upc == 2));
  a_r12_upc_range: assert property (@(posedge clk) disable iff (!rst_n)
    upc <= 9);
endmodule

bind mseq_top mseq_chk #(.OPC_W(OPC_W), .UADDR_W(UADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opcode     (opcode),
  .upc        (upc),
  .illegal_op (illegal_op)
);

// File: tb/mseq_top_tb.sv
module mseq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic [3:0] upc;
  logic [1:0] alu_op, src2_sel, rf_ctl, mem_ctl, pc_ctl;
  logic       src1_sel, illegal_op;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
    .alu_op(alu_op), .src1_sel(src1_sel), .src2_sel(src2_sel),
    .rf_ctl(rf_ctl), .mem_ctl(mem_ctl), .pc_ctl(pc_ctl), .illegal_op(illegal_op)
  );

  // vector: opcode[28:23] length[22:20] upc path[19:0], step 0 in bits [3:0]
  localparam logic [28:0] VEC [6] = '{
    {6'h23, 3'd5, 20'h43210},   // R5 load
    {6'h2B, 3'd4, 20'h05210},   // R6 store
    {6'h00, 3'd4, 20'h07610},   // R7 register ALU
    {6'h04, 3'd3, 20'h00810},   // R8 branch-equal
    {6'h02, 3'd3, 20'h00910},   // R9 jump
    {6'h23, 3'd5, 20'h43210}    // R5 load again, back to back
  };

  localparam string VREQ [6] = '{"R5", "R6", "R7", "R8", "R9", "R5"};

  // expected {alu_op, src1, src2, rf, mem, pc} for a micro-address, from the requirements
  function automatic logic [10:0] exp_ctl(int a);
    case (a)
      0: return {2'd0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1};
      1: return {2'd0, 1'b0, 2'd3, 2'd1, 2'd0, 2'd0};
      2: return {2'd0, 1'b1, 2'd2, 2'd0, 2'd0, 2'd0};
      3: return {2'd0, 1'b0, 2'd0, 2'd0, 2'd2, 2'd0};
      4: return {2'd0, 1'b0, 2'd0, 2'd3, 2'd0, 2'd0};
      5: return {2'd0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd0};
      6: return {2'd2, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0};
      7: return {2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 2'd0};
      8: return {2'd1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd2};
      9: return {2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd3};
      default: return '0;
    endcase
  endfunction

  function automatic logic [10:0] act_ctl();
    return {alu_op, src1_sel, src2_sel, rf_ctl, mem_ctl, pc_ctl};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one check of upc, controls and illegal flag together
  task automatic chk_step(input string req, input int exp_upc, input logic exp_ill);
    chk(req, "state", {16'd0, upc, act_ctl(), illegal_op},
                      {16'd0, 4'(exp_upc), exp_ctl(exp_upc), exp_ill});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds fetch
    repeat (3) @(negedge clk);
    chk_step("R1", 0, 1'b0);
    rst_n = 1'b1;
    chk_step("R1", 0, 1'b0);
    tick();
    chk_step("R2", 1, 1'b0);   // R2: fetch advances; R3 decode word shown
    tick();                     // opcode 0x00 dispatched to 6
    chk_step("R3", 6, 1'b0);
    tick();
    tick();
    chk_step("R12", 0, 1'b0);

    // table walk, one vector per instruction class
    for (int v = 0; v < 6; v++) begin
      opcode = VEC[v][28:23];
      for (int s = 0; s < int'(VEC[v][22:20]); s++) begin
        chk_step(VREQ[v], int'(VEC[v][s*4 +: 4]), 1'b0);
        tick();
      end
      chk_step(VREQ[v], 0, 1'b0);   // back at fetch after the last word
    end

    // R10: no entry in the first lookup
    opcode = 6'h3F;
    tick();
    chk_step("R10", 1, 1'b1);
    tick();
    chk_step("R10", 0, 1'b0);

    // R11: opcode changes to one without a second-lookup entry
    opcode = 6'h23;
    tick();
    tick();
    chk_step("R4", 2, 1'b0);
    opcode = 6'h00;
    #1;
    chk_step("R11", 2, 1'b1);
    tick();
    chk_step("R11", 0, 1'b0);

    // R1: asynchronous reset in the middle of a load
    opcode = 6'h23;
    tick(); tick(); tick();
    chk_step("R5", 3, 1'b0);
    rst_n = 1'b0;
    #1;
    chk_step("R1", 0, 1'b0);
    tick();
    chk_step("R1", 0, 1'b0);
    rst_n = 1'b1;
    tick();
    chk_step("R2", 1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule